// File: doc/BRIEF.md
# Scratchpad Memory Function Controller

This block is the byte-level command engine of a single-wire serial EEPROM slave. A bit layer in front of it hands it whole bytes received from the bus master and asks it for bytes to send back. It handles four memory commands: loading an 8-byte volatile scratchpad, reading the scratchpad back with its address and status, committing the scratchpad to a 144-byte array (eighteen 8-byte rows), and streaming the array out.

Writes always pass through the scratchpad. Each of the four 32-byte data pages has its own control byte in the register row at 80h–84h. That byte can freeze the page, so the scratchpad takes the stored byte, or put it in a write-to-zero mode, so the scratchpad takes the AND of the incoming and stored bytes. A commit only starts after the master echoes the two target address bytes and the status byte exactly. The array is a register model that stays busy for a fixed number of clock cycles while it programs a row.

Top module: `spad_mem_ctrl`

## Requirements
- R1: After reset the block sends nothing unasked. The target address is 0000h. The status byte reads 20h (flag bit 7 = 0, incomplete-flag bit 5 = 1, offset bits 2:0 = 0). Every scratchpad byte is FFh. Every array byte is FFh except 85h, which holds the FACTORY_BYTE parameter.
- R2: Command 0Fh takes a target address, low byte first, then data bytes. Each data byte goes to scratchpad offset T[2:0] and then to the following offsets. The status offset holds the offset of the last byte written, or T[2:0] before any data arrives. Bytes after offset 7 are ignored. The incomplete flag (bit 5) clears only when T[2:0] = 0 and offset 7 has been written. Bit 7 is cleared when the address arrives.
- R3: Once offset 7 has been written during 0Fh, read requests return the inverted CRC-16 low byte and then the inverted high byte, followed by FFh. The CRC uses x^16+x^15+x^2+1, LSB first, starts at 0, and covers the command, both address bytes and the data as received. Before offset 7 is written, reads return FFh.
- R4: For an address in a data page, control byte 55h makes the scratchpad load the stored byte and AAh makes it load the bitwise AND of the incoming and stored bytes. Any other value loads the incoming byte unchanged.
- R5: In the register row, bytes 80h–84h each refuse new data, loading the stored byte instead, once they hold 55h or AAh. Byte 85h always refuses new data. Bytes 86h–87h refuse new data only when 85h holds AAh. Bytes 88h–8Fh accept anything.
- R6: Command AAh returns the address low byte, the address high byte, the status byte, then the scratchpad from offset T[2:0] through the status offset. After that it returns the inverted CRC-16 (low byte, then high) of the command and every byte sent, and then FFh.
- R7: Command 55h followed by three bytes starts a commit only if all of these hold: the three bytes equal the address low byte, the address high byte and the status byte; the address is at most 8Fh; the incomplete flag is clear; no programming is in progress; and R9 does not block the row. A refused commit returns FFh, leaves bit 7 clear and leaves the array unchanged.
- R8: An accepted commit sets status bit 7 and writes all 8 scratchpad bytes into the addressed row after PROG_CYCLES clocks. Reads return FFh until programming ends and AAh afterwards.
- R9: When byte 84h holds 55h or AAh, commits to rows 80h–8Fh and to pages whose control byte is 55h are refused. Without that, a frozen page still accepts a commit, which rewrites it with its current data.
- R10: Command F0h takes an address and returns array bytes from it upward, then FFh past 8Fh. The scratchpad, target address and status are unchanged by it.
- R11: Asserting cmd_abort ends any command. The next received byte is treated as a command.
- R12: An unknown command byte makes the block ignore received bytes and return FFh until the next abort.
- R13: Each tx_req cycle is followed in the next cycle by exactly one tx_valid cycle carrying the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_abort | input | 1 | Bus reset seen by the bit layer; returns the engine to command state |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| tx_req | input | 1 | The bit layer needs the next byte to send |
| tx_valid | output | 1 | Answer to the previous cycle's tx_req |
| tx_data | output | 8 | Byte to send |

## Verification
The bench builds the block with PROG_CYCLES set to 24. This keeps each commit short enough that dozens of them, each followed by an array readback, fit in the run, and it lets the busy phase (FFh) and the done phase (AAh) both be sampled. FACTORY_BYTE keeps its default of 55h, so the checks see 85h frozen and 86h/87h open. The register-row settings reach every protection mode in turn: open, frozen, write-to-zero, and copy-locked.

// File: rtl/spmc_pkg.sv
package spmc_pkg;
  localparam int SP_BYTES = 8;

  localparam logic [7:0] CMD_WR_SP  = 8'h0F;
  localparam logic [7:0] CMD_RD_SP  = 8'hAA;
  localparam logic [7:0] CMD_COPY   = 8'h55;
  localparam logic [7:0] CMD_RD_MEM = 8'hF0;

  localparam logic [7:0] LOCK_FREEZE = 8'h55;
  localparam logic [7:0] LOCK_ZERO   = 8'hAA;
  localparam logic [7:0] DONE_BYTE   = 8'hAA;

  typedef enum logic [1:0] {PM_OPEN, PM_FROZEN, PM_ANDED} prot_mode_e;

  typedef enum logic [3:0] {
    S_CMD, S_ALO, S_AHI, S_WS, S_RS, S_CPA, S_CPR, S_RM, S_SINK
  } eng_state_e;

  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic is_lock(input logic [7:0] b);
    return (b == LOCK_FREEZE) || (b == LOCK_ZERO);
  endfunction
endpackage

// File: rtl/spmc_prot.sv
module spmc_prot
  import spmc_pkg::*;
#(
  parameter int DATA_BYTES = 128
) (
  input  logic [15:0]     load_addr,
  input  logic [15:0]     copy_addr,
  input  logic [5:0][7:0] reg_bytes,
  output prot_mode_e      load_mode,
  output logic            copy_blk
);
  localparam logic [15:0] REG_LO   = 16'(DATA_BYTES);
  localparam logic [15:0] REG_CPY  = 16'(DATA_BYTES + 4);
  localparam logic [15:0] REG_FAC  = 16'(DATA_BYTES + 5);
  localparam logic [15:0] REG_USR  = 16'(DATA_BYTES + 7);
  localparam logic [15:0] REG_HI   = 16'(DATA_BYTES + 15);

  logic [7:0] page_ctl_load;
  logic [7:0] page_ctl_copy;
  logic [7:0] own_byte;

  assign page_ctl_load = reg_bytes[load_addr[6:5]];
  assign page_ctl_copy = reg_bytes[copy_addr[6:5]];
  assign own_byte      = reg_bytes[load_addr[2:0]];

  always_comb begin
    load_mode = PM_OPEN;
    if (load_addr < REG_LO) begin
      if (page_ctl_load == LOCK_FREEZE)    load_mode = PM_FROZEN;
      else if (page_ctl_load == LOCK_ZERO) load_mode = PM_ANDED;
    end else if (load_addr <= REG_CPY) begin
      if (is_lock(own_byte)) load_mode = PM_FROZEN;
    end else if (load_addr == REG_FAC) begin
      load_mode = PM_FROZEN;
    end else if (load_addr <= REG_USR) begin
      if (reg_bytes[5] == LOCK_ZERO) load_mode = PM_FROZEN;
    end
  end

  always_comb begin
    copy_blk = 1'b0;
    if (is_lock(reg_bytes[4])) begin
      if ((copy_addr >= REG_LO) && (copy_addr <= REG_HI)) copy_blk = 1'b1;
      else if ((copy_addr < REG_LO) && (page_ctl_copy == LOCK_FREEZE)) copy_blk = 1'b1;
    end
  end
endmodule

// File: rtl/spmc_mem_array.sv
module spmc_mem_array
  import spmc_pkg::*;
#(
  parameter int         MEM_BYTES    = 144,
  parameter int         PROG_CYCLES  = 1000000,
  parameter logic [7:0] FACTORY_BYTE = 8'h55
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(MEM_BYTES)-1:0]  rd_addr,
  output logic [7:0]                    rd_data,
  output logic [5:0][7:0]               reg_bytes,
  input  logic                          prog_go,
  input  logic [$clog2(MEM_BYTES/SP_BYTES)-1:0] prog_row,
  input  logic [SP_BYTES-1:0][7:0]      prog_data,
  output logic                          prog_busy
);
  localparam int ROWS     = MEM_BYTES / SP_BYTES;
  localparam int RW       = $clog2(ROWS);
  localparam int CW       = $clog2(PROG_CYCLES + 1);
  localparam int REG_BASE = MEM_BYTES - 2 * SP_BYTES;

  logic [7:0]               mem_q [MEM_BYTES];
  logic                     busy_q;
  logic [CW-1:0]            cnt_q;
  logic [RW-1:0]            row_q;
  logic [SP_BYTES-1:0][7:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++)
        mem_q[i] <= (i == REG_BASE + 5) ? FACTORY_BYTE : 8'hFF;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      row_q  <= '0;
      data_q <= '0;
    end else begin
      if (prog_go && !busy_q) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(PROG_CYCLES);
        row_q  <= prog_row;
        data_q <= prog_data;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          for (int j = 0; j < SP_BYTES; j++)
            mem_q[int'(row_q) * SP_BYTES + j] <= data_q[j];
        end
      end
    end
  end

  assign rd_data   = (int'(rd_addr) < MEM_BYTES) ? mem_q[rd_addr] : 8'hFF;
  assign prog_busy = busy_q;

  for (genvar g = 0; g < 6; g++) begin : g_regs
    assign reg_bytes[g] = mem_q[REG_BASE + g];
  end

  // R8: the controller never launches a row while one is being programmed
  assert_go_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |-> !busy_q);

  // R8: the latched row and data stay put for the whole programming window
  assert_row_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> ($stable(row_q) && $stable(data_q)));
endmodule

// File: rtl/spad_mem_ctrl.sv
module spad_mem_ctrl
  import spmc_pkg::*;
#(
  parameter int         MEM_BYTES    = 144,
  parameter int         PROG_CYCLES  = 1000000,
  parameter logic [7:0] FACTORY_BYTE = 8'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_abort,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       tx_req,
  output logic       tx_valid,
  output logic [7:0] tx_data
);
  localparam int          AW         = $clog2(MEM_BYTES);
  localparam int          OFFW       = $clog2(SP_BYTES);
  localparam int          RW         = $clog2(MEM_BYTES / SP_BYTES);
  localparam int          DATA_BYTES = MEM_BYTES - 2 * SP_BYTES;
  localparam logic [15:0] LAST_ADDR  = 16'(MEM_BYTES - 1);
  localparam logic [OFFW-1:0] OFF_END = OFFW'(SP_BYTES - 1);

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  eng_state_e               state_q, state_d;
  logic [7:0]               cmd_q, cmd_d;
  logic [7:0]               alo_q, alo_d;
  logic [15:0]              ta_q, ta_d;
  logic [OFFW-1:0]          e_q, e_d;
  logic                     pf_q, pf_d;
  logic                     aa_q, aa_d;
  logic [SP_BYTES-1:0][7:0] sp_q, sp_d;
  logic [OFFW-1:0]          wp_q, wp_d;
  logic                     full_q, full_d;
  logic [15:0]              crc_q, crc_d;
  logic [2:0]               ph_q, ph_d;
  logic [OFFW-1:0]          rp_q, rp_d;
  logic                     match_q, match_d;
  logic [15:0]              rm_q, rm_d;
  logic                     txv_q, txv_d;
  logic [7:0]               txb_q, txb_d;

  logic [7:0]   es_byte;
  logic [15:0]  cur_addr;
  logic         in_rng;
  logic [7:0]   mem_rd;
  logic [5:0][7:0] reg_bytes;
  prot_mode_e   load_mode;
  logic         copy_blk;
  logic         prog_go;
  logic         prog_busy;
  logic [7:0]   load_byte;

  assign es_byte  = {aa_q, 1'b0, pf_q, 2'b00, e_q};
  assign cur_addr = (state_q == S_RM) ? rm_q : {ta_q[15:OFFW], wp_q};
  assign in_rng   = (cur_addr <= LAST_ADDR);

  spmc_prot #(.DATA_BYTES(DATA_BYTES)) u_prot (
    .load_addr (cur_addr),
    .copy_addr (ta_q),
    .reg_bytes (reg_bytes),
    .load_mode (load_mode),
    .copy_blk  (copy_blk)
  );

  spmc_mem_array #(
    .MEM_BYTES    (MEM_BYTES),
    .PROG_CYCLES  (PROG_CYCLES),
    .FACTORY_BYTE (FACTORY_BYTE)
  ) u_array (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_addr   (cur_addr[AW-1:0]),
    .rd_data   (mem_rd),
    .reg_bytes (reg_bytes),
    .prog_go   (prog_go),
    .prog_row  (ta_q[OFFW +: RW]),
    .prog_data (sp_q),
    .prog_busy (prog_busy)
  );

  always_comb begin
    load_byte = rx_data;
    if (in_rng) begin
      case (load_mode)
        PM_FROZEN: load_byte = mem_rd;
        PM_ANDED:  load_byte = rx_data & mem_rd;
        default:   load_byte = rx_data;
      endcase
    end
  end

  // next-state logic
  always_comb begin
    logic [7:0] v;
    logic [7:0] want;
    logic       ok;
    state_d = state_q;  cmd_d = cmd_q;   alo_d = alo_q;   ta_d = ta_q;
    e_d     = e_q;      pf_d  = pf_q;    aa_d  = aa_q;    sp_d = sp_q;
    wp_d    = wp_q;     full_d = full_q; crc_d = crc_q;   ph_d = ph_q;
    rp_d    = rp_q;     match_d = match_q; rm_d = rm_q;
    txv_d   = tx_req;   txb_d = 8'hFF;   prog_go = 1'b0;
    v = 8'hFF; want = 8'h00; ok = 1'b0;

    if (cmd_abort) begin
      state_d = S_CMD;
      ph_d    = 3'd0;
    end else begin
      if (rx_valid) begin
        case (state_q)
          S_CMD: begin
            cmd_d   = rx_data;
            crc_d   = crc16_byte(16'h0000, rx_data);
            ph_d    = 3'd0;
            match_d = 1'b1;
            rp_d    = ta_q[OFFW-1:0];
            case (rx_data)
              CMD_WR_SP, CMD_RD_MEM: state_d = S_ALO;
              CMD_RD_SP:             state_d = S_RS;
              CMD_COPY:              state_d = S_CPA;
              default:               state_d = S_SINK;
            endcase
          end
          S_ALO: begin
            alo_d   = rx_data;
            crc_d   = crc16_byte(crc_q, rx_data);
            state_d = S_AHI;
          end
          S_AHI: begin
            crc_d = crc16_byte(crc_q, rx_data);
            if (cmd_q == CMD_WR_SP) begin
              ta_d    = {rx_data, alo_q};
              e_d     = alo_q[OFFW-1:0];
              wp_d    = alo_q[OFFW-1:0];
              pf_d    = 1'b1;
              aa_d    = 1'b0;
              full_d  = 1'b0;
              state_d = S_WS;
            end else begin
              rm_d    = {rx_data, alo_q};
              state_d = S_RM;
            end
          end
          S_WS: begin
            if (!full_q) begin
              sp_d[wp_q] = load_byte;
              e_d        = wp_q;
              crc_d      = crc16_byte(crc_q, rx_data);
              if (wp_q == OFF_END) begin
                full_d = 1'b1;
                if (ta_q[OFFW-1:0] == '0) pf_d = 1'b0;
              end else begin
                wp_d = wp_q + 1'b1;
              end
            end
          end
          S_CPA: begin
            case (ph_q)
              3'd0:    want = ta_q[7:0];
              3'd1:    want = ta_q[15:8];
              default: want = es_byte;
            endcase
            ok      = match_q && (rx_data == want);
            match_d = ok;
            if (ph_q == 3'd2) begin
              if (ok && (ta_q <= LAST_ADDR) && !pf_q && !copy_blk && !prog_busy) begin
                aa_d    = 1'b1;
                prog_go = 1'b1;
                state_d = S_CPR;
              end else begin
                state_d = S_SINK;
              end
            end else begin
              ph_d = ph_q + 3'd1;
            end
          end
          default: ;
        endcase
      end

      if (tx_req) begin
        case (state_q)
          S_WS: begin
            if (full_q) begin
              if (ph_q == 3'd0)      begin txb_d = ~crc_q[7:0];  ph_d = 3'd1; end
              else if (ph_q == 3'd1) begin txb_d = ~crc_q[15:8]; ph_d = 3'd2; end
            end
          end
          S_RS: begin
            case (ph_q)
              3'd0: begin v = ta_q[7:0];  ph_d = 3'd1; end
              3'd1: begin v = ta_q[15:8]; ph_d = 3'd2; end
              3'd2: begin v = es_byte;    ph_d = 3'd3; end
              3'd3: begin
                v = sp_q[rp_q];
                if (rp_q == e_q) ph_d = 3'd4;
                else             rp_d = rp_q + 1'b1;
              end
              default: v = 8'hFF;
            endcase
            if (ph_q <= 3'd3) begin
              txb_d = v;
              crc_d = crc16_byte(crc_q, v);
            end else if (ph_q == 3'd4) begin
              txb_d = ~crc_q[7:0];  ph_d = 3'd5;
            end else if (ph_q == 3'd5) begin
              txb_d = ~crc_q[15:8]; ph_d = 3'd6;
            end
          end
          S_CPR: txb_d = prog_busy ? 8'hFF : DONE_BYTE;
          S_RM: begin
            if (in_rng) begin
              txb_d = mem_rd;
              rm_d  = rm_q + 16'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= S_CMD;  cmd_q  <= '0;    alo_q   <= '0;   ta_q  <= '0;
      e_q     <= '0;     pf_q   <= 1'b1;  aa_q    <= 1'b0; sp_q  <= {SP_BYTES{8'hFF}};
      wp_q    <= '0;     full_q <= 1'b0;  crc_q   <= '0;   ph_q  <= '0;
      rp_q    <= '0;     match_q <= 1'b0; rm_q    <= '0;
      txv_q   <= 1'b0;   txb_q  <= 8'hFF;
    end else begin
      state_q <= state_d; cmd_q  <= cmd_d;  alo_q   <= alo_d;   ta_q  <= ta_d;
      e_q     <= e_d;     pf_q   <= pf_d;   aa_q    <= aa_d;    sp_q  <= sp_d;
      wp_q    <= wp_d;    full_q <= full_d; crc_q   <= crc_d;   ph_q  <= ph_d;
      rp_q    <= rp_d;    match_q <= match_d; rm_q  <= rm_d;
      txv_q   <= txv_d;   txb_q  <= txb_d;
    end
  end

  assign tx_valid = txv_q;
  assign tx_data  = txb_q;

  // R13: every request is answered in the following cycle, and only then
  assert_tx_answer_R13: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_req |=> tx_valid);
  assert_tx_quiet_R13: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tx_req |=> !tx_valid);

  // R2: the incomplete flag drops only on a full row written from offset 0
  assert_pf_release_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(pf_q) |-> ((e_q == OFF_END) && (ta_q[OFFW-1:0] == '0)));

  // R7: the accepted flag rises only together with a programming launch
  assert_aa_grant_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(aa_q) |-> $past(prog_go));
endmodule

// File: tb/spad_mem_ctrl_tb.sv
module spad_mem_ctrl_tb;
  localparam int PROGB = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_abort = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       tx_req = 1'b0;
  logic       tx_valid;
  logic [7:0] tx_data;

  always #2 clk = ~clk;

  spad_mem_ctrl #(.MEM_BYTES(144), .PROG_CYCLES(PROGB), .FACTORY_BYTE(8'h55)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_abort(cmd_abort),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_req(tx_req), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  // reference state
  logic [7:0]  mm [0:143];
  logic [7:0]  spm [0:7];
  logic [15:0] tam;
  logic [2:0]  em;
  logic        pfm, aam;

  function automatic logic [15:0] crcb(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = r[0] ^ d[i];
      r = {1'b0, r[15:1]};
      if (fb) r = r ^ 16'hA001;
    end
    return r;
  endfunction

  function automatic bit lk(input logic [7:0] b);
    return (b == 8'h55) || (b == 8'hAA);
  endfunction

  // 0 open, 1 frozen, 2 and-mode
  function automatic int mode_of(input logic [15:0] a);
    if (a < 16'h0080) begin
      if (mm[8'h80 + {6'd0, a[6:5]}] == 8'h55) return 1;
      if (mm[8'h80 + {6'd0, a[6:5]}] == 8'hAA) return 2;
      return 0;
    end
    if (a <= 16'h0084) return lk(mm[a[7:0]]) ? 1 : 0;
    if (a == 16'h0085) return 1;
    if (a <= 16'h0087) return (mm[8'h85] == 8'hAA) ? 1 : 0;
    return 0;
  endfunction

  function automatic bit copy_blocked(input logic [15:0] a);
    if (!lk(mm[8'h84])) return 1'b0;
    if (a[15:4] == 12'h008) return 1'b1;
    if (a < 16'h0080 && mm[8'h80 + {6'd0, a[6:5]}] == 8'h55) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [7:0] es_m();
    return {aam, 1'b0, pfm, 2'b00, em};
  endfunction

  task automatic check(input string r, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic take(input string r, input logic [7:0] exp);
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
    check("R13", {15'd0, tx_valid}, 16'd1);
    check(r, {8'd0, tx_data}, {8'd0, exp});
  endtask

  task automatic abort_pulse();
    @(negedge clk); cmd_abort = 1'b1;
    @(negedge clk); cmd_abort = 1'b0;
  endtask

  task automatic ws(input logic [15:0] a, input int n, input logic [63:0] d);
    logic [15:0] c;
    int off;
    bit full;
    abort_pulse();
    put(8'h0F); put(a[7:0]); put(a[15:8]);
    c = crcb(16'h0, 8'h0F); c = crcb(c, a[7:0]); c = crcb(c, a[15:8]);
    tam = a; em = a[2:0]; pfm = 1'b1; aam = 1'b0; full = 1'b0;
    off = int'(a[2:0]);
    for (int k = 0; k < n && off <= 7; k++) begin
      logic [7:0] b, st;
      logic [15:0] ba;
      b  = d[8*k +: 8];
      ba = {a[15:3], 3'(off)};
      st = (ba <= 16'h008F) ? mm[ba[7:0]] : 8'hFF;
      case (mode_of(ba))
        1:       spm[off] = st;
        2:       spm[off] = b & st;
        default: spm[off] = b;
      endcase
      put(b);
      c  = crcb(c, b);
      em = 3'(off);
      if (off == 7) begin full = 1'b1; if (a[2:0] == 3'd0) pfm = 1'b0; end
      off++;
    end
    if (full) begin
      take("R3", ~c[7:0]);
      take("R3", ~c[15:8]);
      take("R3", 8'hFF);
    end else begin
      take("R3", 8'hFF);
    end
  endtask

  task automatic rs_check(input string r);
    logic [15:0] c;
    abort_pulse();
    put(8'hAA);
    c = crcb(16'h0, 8'hAA);
    take(r, tam[7:0]);  c = crcb(c, tam[7:0]);
    take(r, tam[15:8]); c = crcb(c, tam[15:8]);
    take(r, es_m());    c = crcb(c, es_m());
    for (int k = int'(tam[2:0]); k <= int'(em); k++) begin
      take(r, spm[k]); c = crcb(c, spm[k]);
    end
    take("R6", ~c[7:0]);
    take("R6", ~c[15:8]);
    take("R6", 8'hFF);
  endtask

  task automatic cp(input string r, input logic [7:0] p0, input logic [7:0] p1, input logic [7:0] p2);
    bit grant;
    grant = (p0 == tam[7:0]) && (p1 == tam[15:8]) && (p2 == es_m()) &&
            (tam <= 16'h008F) && !pfm && !copy_blocked(tam);
    abort_pulse();
    put(8'h55); put(p0); put(p1); put(p2);
    if (grant) begin
      take("R8", 8'hFF);
      repeat (PROGB + 4) @(negedge clk);
      take("R8", 8'hAA);
      aam = 1'b1;
      for (int j = 0; j < 8; j++) mm[{tam[7:3], 3'(j)}] = spm[j];
    end else begin
      take(r, 8'hFF);
    end
  endtask

  task automatic cp_ok(input string r);
    cp(r, tam[7:0], tam[15:8], es_m());
  endtask

  task automatic rm(input string r, input logic [15:0] a, input int n);
    logic [15:0] x;
    abort_pulse();
    put(8'hF0); put(a[7:0]); put(a[15:8]);
    x = a;
    for (int k = 0; k < n; k++) begin
      take(r, (x <= 16'h008F) ? mm[x[7:0]] : 8'hFF);
      x++;
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'h5EED_0431);
    for (int i = 0; i < 144; i++) mm[i] = 8'hFF;
    mm[8'h85] = 8'h55;
    for (int i = 0; i < 8; i++) spm[i] = 8'hFF;
    tam = 16'h0; em = 3'd0; pfm = 1'b1; aam = 1'b0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: quiet outputs and reset contents
    check("R1", {15'd0, tx_valid}, 16'd0);
    rs_check("R1");
    rm("R1", 16'h0080, 8);

    // R2 R3 R8: full row to page 0, committed and read back
    ws(16'h0000, 8, 64'h0123_4567_89AB_CDEF);
    rs_check("R2");
    cp_ok("R7");
    rs_check("R8");
    rm("R8", 16'h0000, 8);

    // R2 R7: partial row starting mid-row leaves the flag set, commit refused
    ws(16'h0023, 2, 64'h0000_0000_0000_5AA5);
    rs_check("R2");
    cp_ok("R7");
    rm("R7", 16'h0020, 8);

    // R3: reaching offset 7 from offset 5 still yields the CRC, flag stays set
    ws(16'h0045, 3, 64'h0000_0000_00C3_3C96);
    rs_check("R3");

    // R7: wrong echo refused, right echo accepted
    ws(16'h0040, 8, 64'hDEAD_BEEF_F00D_1234);
    cp("R7", tam[7:0], tam[15:8], es_m() ^ 8'h01);
    rs_check("R7");
    cp_ok("R7");
    rm("R8", 16'h0040, 8);

    // R4 R5: page 0 frozen, page 1 in and-mode
    ws(16'h0080, 8, 64'h4433_7700_2211_AA55);
    rs_check("R5");
    cp_ok("R5");
    rm("R5", 16'h0080, 8);
    ws(16'h0000, 8, 64'h1111_2222_3333_4444);
    rs_check("R4");
    cp_ok("R9");
    rm("R9", 16'h0000, 8);
    ws(16'h0020, 8, 64'h0F0F_F0F0_3C3C_C3C3);
    rs_check("R4");
    cp_ok("R4");
    rm("R4", 16'h0020, 8);

    // R5: locked register bytes refuse change, others take it
    ws(16'h0080, 8, 64'hAB_CD_00_00_00_00_00_00);
    rs_check("R5");

    // R9: copy lock
    ws(16'h0080, 8, 64'h4433_77AA_0000_0000);
    rs_check("R5");
    cp_ok("R9");
    ws(16'h0000, 8, 64'h9999_8888_7777_6666);
    cp_ok("R9");
    rs_check("R9");
    ws(16'h0080, 8, 64'h0);
    cp_ok("R9");
    ws(16'h0050, 8, 64'h1357_9BDF_2468_ACE0);
    cp_ok("R9");
    rm("R9", 16'h0050, 8);

    // random traffic on pages 1..3 and the reserved row
    for (int it = 0; it < 30; it++) begin
      logic [15:0] a;
      int n;
      int rsel;
      rsel = int'($urandom_range(0, 12));
      a = (rsel == 12) ? 16'h0088 : 16'(32 + rsel * 8);
      a[2:0] = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(1, 7)) : 3'd0;
      n = int'($urandom_range(1, 8 - int'(a[2:0])));
      ws(a, n, rnd64());
      rs_check("R6");
      if ($urandom_range(0, 3) == 0) cp("R7", tam[7:0], tam[15:8], es_m() ^ 8'h40);
      else                           cp_ok("R7");
      rm("R10", {a[15:3], 3'd0}, 8);
    end

    // R10: stream past the end and no disturbance
    rm("R10", 16'h008C, 6);
    rs_check("R10");

    // R11: abort mid-address and mid-echo
    abort_pulse();
    put(8'h0F); put(8'h08);
    rs_check("R11");
    abort_pulse();
    put(8'h55); put(tam[7:0]);
    rs_check("R11");

    // R12: unknown command
    abort_pulse();
    put(8'h3C);
    take("R12", 8'hFF);
    put(8'h0F);
    take("R12", 8'hFF);
    rs_check("R12");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule